// File: doc/BRIEF.md
# Link BIST Error Checker

This block sits behind the receiver of a high-speed serial link and judges an at-speed self test. The system raises a test-enable input and holds it for as long as it wants the test to run. Once the receiver reports lock while the enable is high, a test window opens. During the window each received payload word, qualified by a valid strobe, is compared against a locally regenerated pseudo-random word. Any mismatch, or any loss of lock, marks the test as failed.

When the enable falls, the window closes. The result is frozen on a pass output and stays there until the next window opens. Words that arrive after the close have no effect on the result. A saturating counter of mismatched words in the window is provided as a build option.

Top module: `link_bist_checker`

## Requirements
- R1: After reset, pass_o is 0 and err_cnt_o is 0.
- R2: A window opens on a rising clock edge only when lock_i and bist_en_i are both 1 and no window is open. If bist_en_i is high while lock_i is low, no window opens and pass_o keeps its value.
- R3: An open window closes on the first rising edge at which bist_en_i is 0. On that edge pass_o takes the test result.
- R4: If every valid word in the window matched, pass_o is 1 after the close. Cycles with rx_valid_i at 0 are not compared and do not advance the expected sequence, whatever rx_word_i carries.
- R5: If one or more valid words in the window mismatched, pass_o is 0 after the close. The error state is sticky for the rest of the window.
- R6: Once the window is closed, pass_o and err_cnt_o hold until the next window opens. Words that arrive after the close, matching or not, change neither of them.
- R7: The expected words come from the PRBS-7 sequence x^7+x^6+1, with 7-bit state s. Each step computes the bit b = s[6]^s[5] and shifts s to {s[5:0],b}. A word takes DATA_W consecutive bits, the first bit in the MSB. The state is loaded with SEED (default 7'h55) when each window opens and advances by one word per valid word.
- R8: If lock_i is 0 during any cycle of an open window while bist_en_i is 1, the test fails (pass_o 0 after close). This does not add to the mismatch count.
- R9: err_cnt_o counts mismatched valid words in the window. It is cleared when a window opens and saturates at 255.
- R10: While a window is open, pass_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Receiver lock indicator |
| bist_en_i | input | 1 | Test enable; its high time sets the window length |
| rx_valid_i | input | 1 | Strobe for rx_word_i |
| rx_word_i | input | DATA_W (10) | Received payload word |
| pass_o | output | 1 | Frozen test result, 1 = error free |
| err_cnt_o | output | CNT_W (8) | Saturating count of mismatched words |

## Verification
The bench sweeps the position of a single corrupted word across the window. A flag that is not sticky, or that misses the first or the last word, would then report a pass. It sends bursts of mismatches with the enable low after a passing test, which catches a design that keeps comparing once the window has closed. Idle cycles carry garbage data to catch a generator that steps on invalid cycles. The bench also sends more than 255 bad words to expose a counter that wraps. Finally, it drops lock for one cycle inside an otherwise clean window, and holds the enable high with lock low, to catch a result that ignores lock or a window that opens without it.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int PRBS_LEN = 7;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_RUN = 1'b1} win_state_e;
endpackage

// File: rtl/bist_prbs_gen.sv
module bist_prbs_gen
  import bist_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter logic [PRBS_LEN-1:0] SEED = 7'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed_i,
  input  logic              adv_i,
  output logic [DATA_W-1:0] exp_o
);
  logic [PRBS_LEN-1:0] state_q, state_d, state_adv;
  logic [DATA_W-1:0]   word;

  // Parallel unroll of DATA_W serial steps, first bit into MSB
  always_comb begin
    logic [PRBS_LEN-1:0] s;
    logic nb;
    s = state_q;
    word = '0;
    for (int k = 0; k < DATA_W; k++) begin
      nb = s[6] ^ s[5];
      word[DATA_W-1-k] = nb;
      s = {s[5:0], nb};
    end
    state_adv = s;
  end

  always_comb begin
    state_d = state_q;
    if (reseed_i)   state_d = SEED;
    else if (adv_i) state_d = state_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign exp_o = word;

  a_r7_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  a_r7_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    reseed_i |=> state_q == SEED);
endmodule

// File: rtl/bist_window_ctrl.sv
module bist_window_ctrl
  import bist_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic en_i,
  output logic open_o,
  output logic close_o,
  output logic win_o
);
  win_state_e st_q, st_d;

  always_comb begin
    open_o  = 1'b0;
    close_o = 1'b0;
    st_d    = st_q;
    case (st_q)
      WIN_IDLE: if (lock_i && en_i) begin open_o = 1'b1; st_d = WIN_RUN; end
      WIN_RUN:  if (!en_i)          begin close_o = 1'b1; st_d = WIN_IDLE; end
      default:  st_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WIN_IDLE;
    else        st_q <= st_d;
  end

  assign win_o = (st_q == WIN_RUN);

  a_r2_open_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_o && !(lock_i && en_i)) |=> !win_o);
  a_r3_close_on_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o && !en_i) |=> !win_o);
endmodule

// File: rtl/bist_err_track.sv
module bist_err_track #(
  parameter int CNT_W  = 8,
  parameter bit CNT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             win_i,
  input  logic             en_i,
  input  logic             lock_i,
  input  logic             valid_i,
  input  logic             mismatch_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic err_q, err_d, pass_q, pass_d;
  logic live, bad_word;

  assign live     = win_i && en_i;
  assign bad_word = live && valid_i && mismatch_i;

  always_comb begin
    err_d  = err_q;
    pass_d = pass_q;
    if (open_i) begin
      err_d  = 1'b0;
      pass_d = 1'b0;
    end else begin
      if (bad_word || (live && !lock_i)) err_d = 1'b1;
      if (close_i) pass_d = !err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      pass_q <= pass_d;
    end
  end

  assign pass_o = pass_q;

  generate
    if (CNT_EN) begin : g_cnt
      logic [CNT_W-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d = cnt_q;
        if (open_i)                           cnt_d = '0;
        else if (bad_word && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign cnt_o = cnt_q;

      a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !open_i) |=> cnt_q == CNT_MAX);
      a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_i && !open_i) |=> $stable(cnt_q));
    end else begin : g_nocnt
      assign cnt_o = '0;
    end
  endgenerate

  a_r10_pass_low_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    win_i |-> !pass_o);
  a_r6_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_i && !open_i) |=> $stable(pass_o));
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (win_i && err_q && !open_i && !close_i) |=> err_q);
endmodule

// File: rtl/link_bist_checker.sv
module link_bist_checker
  import bist_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 8,
  parameter bit CNT_EN = 1'b1,
  parameter logic [PRBS_LEN-1:0] SEED = 7'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              bist_en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              pass_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic open_w, close_w, win_w, adv_w, mism_w;
  logic [DATA_W-1:0] exp_w;

  bist_window_ctrl u_win (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .en_i(bist_en_i),
    .open_o(open_w), .close_o(close_w), .win_o(win_w)
  );

  assign adv_w  = win_w && bist_en_i && rx_valid_i;
  assign mism_w = (rx_word_i != exp_w);

  bist_prbs_gen #(.DATA_W(DATA_W), .SEED(SEED)) u_gen (
    .clk(clk), .rst_n(rst_n), .reseed_i(open_w), .adv_i(adv_w), .exp_o(exp_w)
  );

  bist_err_track #(.CNT_W(CNT_W), .CNT_EN(CNT_EN)) u_err (
    .clk(clk), .rst_n(rst_n), .open_i(open_w), .close_i(close_w),
    .win_i(win_w), .en_i(bist_en_i), .lock_i(lock_i), .valid_i(rx_valid_i),
    .mismatch_i(mism_w), .pass_o(pass_o), .cnt_o(err_cnt_o)
  );
endmodule

// File: tb/tb_link_bist_checker.sv
module tb_link_bist_checker;
  localparam int W = 10;
  localparam logic [6:0] SEED = 7'h55;

  logic clk = 1'b0;
  logic rst_n, lock, en, valid;
  logic [W-1:0] word;
  logic pass;
  logic [7:0] cnt;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [6:0] m_st;

  always #5 clk = ~clk;

  link_bist_checker dut (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .bist_en_i(en),
    .rx_valid_i(valid), .rx_word_i(word), .pass_o(pass), .err_cnt_o(cnt)
  );

  // Model: next W bits of the sequence in a bit-serial stream
  function automatic logic [W-1:0] model_word(inout logic [6:0] st);
    logic [W-1:0] w;
    for (int i = W-1; i >= 0; i--) begin
      logic b;
      b = st[6] ^ st[5];
      w[i] = b;
      st = {st[5:0], b};
    end
    return w;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic open_win();
    en = 1; lock = 1; valid = 0; tick(); m_st = SEED;
  endtask
  task automatic send(bit good);
    logic [W-1:0] w;
    w = model_word(m_st);
    valid = 1; word = good ? w : (w ^ 10'h001); tick(); valid = 0;
  endtask
  task automatic idle_garbage();
    valid = 0; word = 10'h3A5; tick();
  endtask
  task automatic close_win();
    en = 0; valid = 0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lock = 0; en = 0; valid = 0; word = '0;
    tick(); tick();
    chk("R1 pass", pass, 0);
    chk("R1 cnt", cnt, 0);
    rst_n = 1; tick();

    // R4/R7 clean run with idle garbage
    open_win();
    chk("R10 pass low in window", pass, 0);
    for (int i = 0; i < 20; i++) begin
      send(1);
      if (i % 3 == 0) idle_garbage();
    end
    close_win();
    chk("R4 clean pass", pass, 1);
    chk("R4 clean cnt", cnt, 0);

    // R2 enable without lock: no window
    en = 1; lock = 0; repeat (5) tick();
    chk("R2 no open without lock", pass, 1);
    en = 0; tick();

    // R6 mismatches after close
    valid = 1;
    for (int i = 0; i < 8; i++) begin word = 10'(i * 77); tick(); end
    valid = 0;
    chk("R6 pass held", pass, 1);
    chk("R6 cnt held", cnt, 0);

    // R5 single error swept across positions
    for (int k = 0; k < 8; k++) begin
      open_win();
      for (int i = 0; i < 8; i++) send(i != k);
      chk("R10 pass low before close", pass, 0);
      close_win();
      chk("R5 single error pass", pass, 0);
      chk("R9 single error cnt", cnt, 1);
    end

    // R3 close, then clean reopen passes (R7 reseed)
    open_win();
    for (int i = 0; i < 5; i++) send(1);
    close_win();
    chk("R3 R7 reseed pass", pass, 1);

    // R9 multiple errors
    open_win();
    for (int i = 0; i < 12; i++) send(i % 2 == 0);
    close_win();
    chk("R9 count six", cnt, 6);
    chk("R5 multi pass", pass, 0);

    // R9 saturation
    open_win();
    for (int i = 0; i < 300; i++) send(0);
    close_win();
    chk("R9 saturate", cnt, 255);
    open_win();
    chk("R9 cleared on open", cnt, 0);
    close_win();
    chk("R4 empty window pass", pass, 1);

    // R8 lock drop in window
    open_win();
    for (int i = 0; i < 3; i++) send(1);
    lock = 0; tick(); lock = 1;
    for (int i = 0; i < 3; i++) send(1);
    close_win();
    chk("R8 lock drop fail", pass, 0);
    chk("R8 no mismatch count", cnt, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule